// File: doc/BRIEF.md
# Dual-Pixel Arrival-Time and Pulse-Width Counter Cell

This block is the shared digital logic behind two neighbouring detector pixels. While a frame window is open, each pixel watches its own discriminator line. The first rising edge on that line marks the pixel as hit. From that edge to the end of the window the pixel counts an arrival-time value. It also counts a pulse-width value for as long as that first pulse stays high. Both values are kept in 4-bit saturating linear-feedback counters, which are cheaper than binary counters. For threshold equalisation, a counting mode makes the arrival-time counter tally discriminator edges instead.

After the window closes, the same counter flip-flops form one segment of a column-long serial chain. Bits enter from the neighbour below on `sin_*` and leave towards the neighbour above on `sout_*`. One valid/ready handshake moves the whole chain by one bit. A transfer happens only in a cycle where readout is asserted, `sin_valid` is high and `sout_ready` is high. `sin_ready` follows `sout_ready` and `sout_valid` follows `sin_valid`, both only while readout is high. When `sout_ready` is low, back-pressure stalls the chain and every stored bit holds. Per-pixel hit flags let column logic skip empty pixels.

All registers use one clock. `acq_en` is a strobe that marks the cycles in which acquisition counters may advance.

Top module: `pix_pair_cell`

## Requirements
- R1: After reset, both counter fields of every pixel hold the seed 4'b1110, so a full readout yields 8'hEE per pixel, and all hit flags and `sout_valid` are 0.
- R2: `shutter` and each `disc` bit pass through two flip-flops before use. A window or pulse that begins on input cycle c acts from cycle c+2. Input edges that are one cycle apart stay one cycle apart internally.
- R3: Each counter step shifts the 4-bit value left and inserts bit3 XOR bit0 as the new bit0. A counter at 4'b1111 holds there, which happens after 14 steps from the seed.
- R4: In timing mode (`calib_mode`=0), the arrival-time field steps once per `acq_en` cycle from the cycle after the pixel's first synchronised rising edge until the synchronised window closes.
- R5: In timing mode, the pulse-width field steps once per `acq_en` cycle while the first synchronised pulse stays high after its rising edge. Later pulses in the same window do not change it.
- R6: In counting mode (`calib_mode`=1), the arrival-time field steps once per synchronised rising edge of the pixel's discriminator, regardless of `acq_en`, and the pulse-width field keeps the seed.
- R7: A pixel whose `mask` bit is 1 never sets its hit flag and its counters keep the seed for that window.
- R8: The synchronised rising edge of the window resets every counter to the seed and clears every hit flag. A discriminator edge in that same cycle is lost.
- R9: Readout order is pixel NPIX-1 first, each pixel's word as {arrival[3:0], width[3:0]}, MSB first. A bit accepted on `sin_data` enters pixel 0's width LSB and leaves on `sout_data` after 8*NPIX further transfers.
- R10: `sin_ready` is 1 exactly when readout is high and `sout_ready` is 1. `sout_valid` is 1 exactly when readout is high and `sin_valid` is 1. Without a transfer, `sout_data` holds on the next cycle.
- R11: While readout is high, acquisition is frozen: hit flags do not change and no counter steps.
- R12: An unmasked pixel sets its hit flag on its first synchronised discriminator rising edge inside an open window, in either mode. The flag stays set until the next window opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock for acquisition and readout |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_en | input | 1 | Acquisition step strobe |
| shutter | input | 1 | Frame window, asynchronous |
| readout | input | 1 | Selects serial chain operation |
| calib_mode | input | 1 | 0 timing mode, 1 edge counting mode |
| mask | input | NPIX | Per-pixel disable |
| disc | input | NPIX | Per-pixel discriminator, asynchronous |
| sin_valid | input | 1 | Upstream bit offered |
| sin_ready | output | 1 | Chain can accept the upstream bit |
| sin_data | input | 1 | Upstream serial bit |
| sout_valid | output | 1 | Bit offered downstream |
| sout_ready | input | 1 | Downstream accepts the bit |
| sout_data | output | 1 | Serial bit towards the next cell |
| hit_flag | output | NPIX | Per-pixel hit indication |

## Verification
Several properties are checked on every cycle. A masked pixel never raises its flag. A flag falls only after a window-open pulse. Readout freezes the flags. A stalled chain keeps its output bit, and the handshake pass-through holds. Counter values depend on the full input history, so only the bench scenarios can show them. These scenarios cover exact step counts, saturation at the terminal state, the single-pulse rule for width, edge counting in calibration mode, the serial bit order, and the way shifted-in bits pass through the chain under random back-pressure.

// File: rtl/pix_pkg.sv
package pix_pkg;

  parameter int unsigned CNT_W = 4;
  parameter int unsigned FB_TAP = 0;
  localparam int unsigned WORD_W = 2 * CNT_W;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t CNT_TOP  = {CNT_W{1'b1}};
  localparam cnt_t CNT_SEED = {{(CNT_W-1){1'b1}}, 1'b0};

  typedef struct packed {
    cnt_t arr;
    cnt_t wid;
  } pix_word_t;

  typedef enum logic {
    MODE_TIMING = 1'b0,
    MODE_COUNT  = 1'b1
  } acq_mode_e;

  function automatic cnt_t lfsr_sat_step(input cnt_t q);
    cnt_t r;
    if (q == CNT_TOP) begin
      r = q;
    end else begin
      r = {q[CNT_W-2:0], q[CNT_W-1] ^ q[FB_TAP]};
    end
    return r;
  endfunction

endpackage

// File: rtl/pix_sync.sv
module pix_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic st1, st2;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st1 <= 1'b0;
          st2 <= 1'b0;
        end else begin
          st1 <= d_async[i];
          st2 <= st1;
        end
      end
      assign d_sync[i] = st2;
    end
  endgenerate

endmodule

// File: rtl/pix_ctrl.sv
module pix_ctrl #(
  parameter int unsigned NPIX = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shutter,
  input  logic [NPIX-1:0] disc,
  output logic            win_lvl,
  output logic            win_open,
  output logic [NPIX-1:0] dsc_lvl,
  output logic [NPIX-1:0] dsc_rise
);

  localparam int unsigned SW = NPIX + 1;

  logic [SW-1:0]   raw_in;
  logic [SW-1:0]   synced;
  logic            win_prev;
  logic [NPIX-1:0] dsc_prev;

  assign raw_in = {disc, shutter};

  pix_sync #(.W(SW)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(raw_in),
    .d_sync (synced)
  );

  assign win_lvl = synced[0];
  assign dsc_lvl = synced[SW-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_prev <= 1'b0;
      dsc_prev <= '0;
    end else begin
      win_prev <= win_lvl;
      dsc_prev <= dsc_lvl;
    end
  end

  assign win_open = win_lvl & ~win_prev;
  assign dsc_rise = dsc_lvl & ~dsc_prev;

endmodule

// File: rtl/pix_channel.sv
module pix_channel
  import pix_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rdo,
  input  logic      shift_en,
  input  logic      shift_in,
  output logic      shift_out,
  input  logic      acq_en,
  input  acq_mode_e mode,
  input  logic      masked,
  input  logic      win_lvl,
  input  logic      win_open,
  input  logic      dsc_lvl,
  input  logic      dsc_rise,
  output logic      hit
);

  pix_word_t word_q, word_n;
  logic      hit_q, hit_n;
  logic      wid_run_q, wid_run_n;

  always_comb begin
    word_n    = word_q;
    hit_n     = hit_q;
    wid_run_n = wid_run_q;
    if (rdo) begin
      if (shift_en) begin
        word_n = pix_word_t'({word_q[WORD_W-2:0], shift_in});
      end
    end else if (win_open) begin
      word_n.arr = CNT_SEED;
      word_n.wid = CNT_SEED;
      hit_n      = 1'b0;
      wid_run_n  = 1'b0;
    end else if (win_lvl && !masked) begin
      if (mode == MODE_COUNT) begin
        if (dsc_rise) begin
          hit_n      = 1'b1;
          word_n.arr = lfsr_sat_step(word_q.arr);
        end
      end else begin
        if (dsc_rise && !hit_q) begin
          hit_n     = 1'b1;
          wid_run_n = 1'b1;
        end
        if (hit_q && acq_en) begin
          word_n.arr = lfsr_sat_step(word_q.arr);
        end
        if (wid_run_q) begin
          if (dsc_lvl) begin
            if (acq_en) begin
              word_n.wid = lfsr_sat_step(word_q.wid);
            end
          end else begin
            wid_run_n = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '{arr: CNT_SEED, wid: CNT_SEED};
      hit_q     <= 1'b0;
      wid_run_q <= 1'b0;
    end else begin
      word_q    <= word_n;
      hit_q     <= hit_n;
      wid_run_q <= wid_run_n;
    end
  end

  assign shift_out = word_q[WORD_W-1];
  assign hit       = hit_q;

endmodule

// File: rtl/pix_pair_cell.sv
module pix_pair_cell
  import pix_pkg::*;
#(
  parameter int unsigned NPIX = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acq_en,
  input  logic            shutter,
  input  logic            readout,
  input  logic            calib_mode,
  input  logic [NPIX-1:0] mask,
  input  logic [NPIX-1:0] disc,
  input  logic            sin_valid,
  output logic            sin_ready,
  input  logic            sin_data,
  output logic            sout_valid,
  input  logic            sout_ready,
  output logic            sout_data,
  output logic [NPIX-1:0] hit_flag
);

  logic            win_lvl;
  logic            open_pls;
  logic [NPIX-1:0] dsc_lvl;
  logic [NPIX-1:0] dsc_rise;
  logic            xfer;
  logic [NPIX:0]   link;
  acq_mode_e       mode_sel;

  assign mode_sel   = acq_mode_e'(calib_mode);
  assign sin_ready  = readout & sout_ready;
  assign sout_valid = readout & sin_valid;
  assign xfer       = readout & sin_valid & sout_ready;

  pix_ctrl #(.NPIX(NPIX)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .shutter (shutter),
    .disc    (disc),
    .win_lvl (win_lvl),
    .win_open(open_pls),
    .dsc_lvl (dsc_lvl),
    .dsc_rise(dsc_rise)
  );

  assign link[0] = sin_data;

  genvar p;
  generate
    for (p = 0; p < NPIX; p++) begin : g_pix
      pix_channel u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .rdo      (readout),
        .shift_en (xfer),
        .shift_in (link[p]),
        .shift_out(link[p+1]),
        .acq_en   (acq_en),
        .mode     (mode_sel),
        .masked   (mask[p]),
        .win_lvl  (win_lvl),
        .win_open (open_pls),
        .dsc_lvl  (dsc_lvl[p]),
        .dsc_rise (dsc_rise[p]),
        .hit      (hit_flag[p])
      );
    end
  endgenerate

  assign sout_data = link[NPIX];

endmodule

// File: rtl/pix_pair_chk.sv
module pix_pair_chk #(
  parameter int unsigned NPIX = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            readout,
  input logic            sin_valid,
  input logic            sin_ready,
  input logic            sout_valid,
  input logic            sout_ready,
  input logic            sout_data,
  input logic [NPIX-1:0] mask,
  input logic [NPIX-1:0] hit_flag,
  input logic            open_pls
);

  genvar p;
  generate
    for (p = 0; p < NPIX; p++) begin : g_px
      assert_mask_blocks_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[p] && !hit_flag[p]) |=> !hit_flag[p]);
      assert_flag_clears_on_open_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hit_flag[p]) |-> $past(open_pls));
    end
  endgenerate

  assert_readout_freezes_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    readout |=> $stable(hit_flag));

  assert_stall_holds_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (readout && !(sin_valid && sout_ready)) |=> $stable(sout_data));

  assert_ready_needs_downstream_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sin_ready |-> (sout_ready && readout));

  assert_valid_needs_upstream_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sout_valid |-> (sin_valid && readout));

endmodule

bind pix_pair_cell pix_pair_chk #(.NPIX(NPIX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .readout   (readout),
  .sin_valid (sin_valid),
  .sin_ready (sin_ready),
  .sout_valid(sout_valid),
  .sout_ready(sout_ready),
  .sout_data (sout_data),
  .mask      (mask),
  .hit_flag  (hit_flag),
  .open_pls  (open_pls)
);

// File: tb/sim_pix_pair_cell.sv
`timescale 1ns/1ps
module sim_pix_pair_cell;

  localparam int NPIX  = 2;
  localparam int CHAIN = NPIX * 8;

  logic clk = 1'b0;
  logic rst_n, acq_en, shutter, readout, calib_mode;
  logic [NPIX-1:0] mask, disc, hit_flag;
  logic sin_valid, sin_ready, sin_data, sout_valid, sout_ready, sout_data;

  int errors = 0;
  int checks = 0;
  bit mon_on = 0;

  always #4 clk = ~clk;

  pix_pair_cell #(.NPIX(NPIX)) u0 (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .shutter(shutter),
    .readout(readout), .calib_mode(calib_mode), .mask(mask), .disc(disc),
    .sin_valid(sin_valid), .sin_ready(sin_ready), .sin_data(sin_data),
    .sout_valid(sout_valid), .sout_ready(sout_ready), .sout_data(sout_data),
    .hit_flag(hit_flag)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // R3 step rule: shift left, new bit0 = bit3 ^ bit0, hold at all ones
  function automatic logic [3:0] nxt4(input logic [3:0] q);
    if (q == 4'hF) return q;
    return {q[2:0], q[3] ^ q[0]};
  endfunction

  // requirement-level reference of acquisition (R2, R4..R8, R11, R12)
  logic m_s1, m_s2, m_sd;
  logic [NPIX-1:0] m_d1, m_d2, m_dd;
  logic [3:0] m_arr [NPIX];
  logic [3:0] m_wid [NPIX];
  logic m_hit [NPIX];
  logic m_run [NPIX];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_sd = 0; m_d1 = '0; m_d2 = '0; m_dd = '0;
      for (int p = 0; p < NPIX; p++) begin
        m_arr[p] = 4'hE; m_wid[p] = 4'hE; m_hit[p] = 0; m_run[p] = 0;
      end
    end else begin
      for (int p = 0; p < NPIX; p++) begin
        logic rise;
        rise = m_d2[p] & ~m_dd[p];
        if (!readout) begin
          if (m_s2 && !m_sd) begin
            m_arr[p] = 4'hE; m_wid[p] = 4'hE; m_hit[p] = 0; m_run[p] = 0;
          end else if (m_s2 && !mask[p]) begin
            if (calib_mode) begin
              if (rise) begin m_hit[p] = 1; m_arr[p] = nxt4(m_arr[p]); end
            end else begin
              logic was_hit, was_run;
              was_hit = m_hit[p]; was_run = m_run[p];
              if (rise && !was_hit) begin m_hit[p] = 1; m_run[p] = 1; end
              if (was_hit && acq_en) m_arr[p] = nxt4(m_arr[p]);
              if (was_run) begin
                if (m_d2[p]) begin
                  if (acq_en) m_wid[p] = nxt4(m_wid[p]);
                end else m_run[p] = 0;
              end
            end
          end
        end
      end
      m_sd = m_s2; m_s2 = m_s1; m_s1 = shutter;
      m_dd = m_d2; m_d2 = m_d1; m_d1 = disc;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      for (int p = 0; p < NPIX; p++)
        chk("R12/R7/R11 hit flag", {31'd0, hit_flag[p]}, {31'd0, m_hit[p]});
    end
  end

  task automatic run_frame(input int len, input logic [63:0] p0, input logic [63:0] p1,
                           input logic [NPIX-1:0] msk, input logic cal, input bit rnd_acq);
    mask = msk;
    calib_mode = cal;
    for (int c = 0; c < len + 6; c++) begin
      @(negedge clk);
      shutter = (c < len);
      disc[0] = (c < len) ? p0[c] : 1'b0;
      disc[1] = (c < len) ? p1[c] : 1'b0;
      acq_en  = rnd_acq ? 1'($urandom % 2) : 1'b1;
    end
    @(negedge clk);
    shutter = 0; disc = '0; acq_en = 1;
  endtask

  task automatic do_readout(input string tag, output logic [CHAIN-1:0] got);
    logic [CHAIN-1:0] pat, exp;
    logic prev;
    bit held;
    int i;
    pat = CHAIN'($urandom);
    for (int p = 0; p < NPIX; p++) exp[p*8 +: 8] = {m_arr[p], m_wid[p]};
    got = '0; i = 0; held = 0; prev = 0;
    while (i < 2 * CHAIN) begin
      @(negedge clk);
      readout    = 1;
      sout_ready = ($urandom % 4) != 0;
      sin_valid  = ($urandom % 4) != 0;
      sin_data   = (i < CHAIN) ? pat[CHAIN-1-i] : 1'b0;
      #1;
      if (held) chk("R10 stalled data holds", {31'd0, sout_data}, {31'd0, prev});
      chk("R10 sin_ready pass-through", {31'd0, sin_ready}, {31'd0, sout_ready});
      chk("R10 sout_valid pass-through", {31'd0, sout_valid}, {31'd0, sin_valid});
      held = !(sin_valid && sout_ready);
      prev = sout_data;
      if (!held) begin
        if (i < CHAIN) got[CHAIN-1-i] = sout_data;
        else chk("R9 shifted-in bit emerges", {31'd0, sout_data}, {31'd0, pat[2*CHAIN-1-i]});
        i++;
      end
    end
    chk({"R9 word order vs model ", tag}, {16'd0, got}, {16'd0, exp});
    @(negedge clk);
    readout = 0; sin_valid = 0; sout_ready = 0; sin_data = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [CHAIN-1:0] got;
    void'($urandom(32'd7321));
    rst_n = 0; acq_en = 1; shutter = 0; readout = 0; calib_mode = 0;
    mask = '0; disc = '0; sin_valid = 0; sin_data = 0; sout_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 hit flags after reset", {30'd0, hit_flag}, 32'd0);
    chk("R1 sout_valid after reset", {31'd0, sout_valid}, 32'd0);
    mon_on = 1;

    do_readout("reset", got);
    chk("R1 reset words", {16'd0, got}, 32'h0000EEEE);

    // R3 saturation, R5 second pulse ignored, R2 equal sync delay
    run_frame(40, 64'h0000_0000_03F0_00F8, 64'h0000_00FF_FFFF_FC00, 2'b00, 1'b0, 0);
    do_readout("A", got);
    chk("R5/R3 width first pulse and saturation", {16'd0, got}, 32'h0000FFFB);

    // R4 exact arrival count, R7 masked pixel keeps seed
    run_frame(10, 64'h30, 64'hFF, 2'b10, 1'b0, 0);
    do_readout("B", got);
    chk("R4/R7 arrival count and mask", {16'd0, got}, 32'h0000EE6D);

    // R6 counting mode: three edges, width stays seed
    run_frame(30, 64'h0003_070C, 64'h0, 2'b00, 1'b1, 0);
    do_readout("C", got);
    chk("R6 edge count mode", {16'd0, got}, 32'h0000EE5E);

    // R8: a hit frame then an empty frame must read back seeds
    run_frame(12, 64'h0, 64'h0, 2'b00, 1'b0, 0);
    do_readout("D", got);
    chk("R8 window open clears", {16'd0, got}, 32'h0000EEEE);

    for (int k = 0; k < 40; k++) begin
      int len;
      logic [63:0] r0, r1;
      len = 8 + int'($urandom % 50);
      r0 = {$urandom, $urandom};
      r1 = {$urandom, $urandom};
      run_frame(len, r0, r1, NPIX'($urandom), 1'(($urandom % 4) == 0), 1);
      do_readout("random", got);
    end

    mon_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule